// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block sits on the result path of a delta-sigma converter and runs its offset and gain calibrations. A command strobe starts one of five calibrations. Three of them measure the converter against internally switched references, and two measure against whatever the system applies at the external input. During each calibration step the block collects a fixed run of raw conversions. It throws away the early ones while the filter settles and averages the rest. From that average it forms either an offset word or a gain word.

When the block is idle, every raw conversion passes through the correction stage. The stage subtracts the stored offset, multiplies by the stored gain and clamps the result to the signed output range. An active-low data-ready line is forced high while a calibration runs and is released when the calibration finishes. A recalibration-needed flag is raised at power-up and whenever the decimation ratio or the amplifier gain changes. A completed calibration clears it. Switching of the converter input is modelled only as a select code that the block drives.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset: busy is 0, drdy_n is 1, recal_req is 1, out_valid is 0, in_sel is 0, offset_reg is 0 and gain_reg is 0x800000 (unity).
- R2: An accepted cmd_code selects the calibration: 1 self offset, 2 self gain, 3 self offset then self gain, 4 system offset, 5 system gain. Codes 0, 6 and 7 are ignored and leave busy at 0.
- R3: Each calibration step consumes exactly seven raw conversions (raw_valid pulses). The first three are discarded. The value measured is floor(sum of the last four / 4). Command 3 consumes fourteen conversions: the offset step first, then the gain step.
- R4: An offset step writes the measured value into offset_reg.
- R5: A gain step writes floor((2^23-1)*2^23 / (measured - offset_reg)) into gain_reg as unsigned Q1.23. The result saturates to 0xFFFFFF, and a difference of zero or less also gives 0xFFFFFF.
- R6: in_sel codes are 0 external input, 1 internal zero, 2 internal reference. A self offset step drives 1, a self gain step drives 2, system steps drive 0, and idle drives 0.
- R7: busy rises on the clock edge that accepts a command and falls on the completion edge. drdy_n is 1 while busy and is 0 right after completion.
- R8: A command that arrives while busy is ignored. It neither restarts nor extends the running calibration.
- R9: When idle, a conversion gives out_valid one cycle later with out_data = clamp(floor((raw - offset_reg) * gain_reg / 2^23)) to [-2^23, 2^23-1]. Conversions taken while busy, or in the cycle a command is accepted, give no output.
- R10: drdy_n is driven high only by the start of a calibration. A corrected output drives it low.
- R11: A dec_change or pga_change pulse sets recal_req, and a completed calibration clears it. A change pulse in the same cycle as completion leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Calibration command code |
| raw_valid | input | 1 | Raw conversion strobe |
| raw_data | input | 24 | Raw conversion, two's complement |
| dec_change | input | 1 | Decimation ratio changed |
| pga_change | input | 1 | Amplifier gain changed |
| out_valid | output | 1 | Corrected result strobe |
| out_data | output | 24 | Corrected result, two's complement |
| offset_reg | output | 24 | Stored offset, two's complement |
| gain_reg | output | 24 | Stored gain, unsigned Q1.23 |
| busy | output | 1 | Calibration in progress |
| drdy_n | output | 1 | Active-low data ready |
| recal_req | output | 1 | Recalibration needed |
| in_sel | output | 2 | Converter input select |

## Verification
The completion of a calibration and a configuration-change strobe can land on the same clock edge. One of them clears the recalibration flag and the other sets it. The bench provokes this by feeding the seventh conversion of a system offset step and then pulsing dec_change exactly on the following edge, which is the edge where busy drops. It judges the outcome by requiring busy low, drdy_n low, the new offset stored and recal_req still high. A scoreboard of predicted corrected outputs also confirms that no result escapes while a calibration holds the path.

// File: rtl/cal_pkg.sv
// Shared types for the calibration sequencer: command codes, input
// select codes and the controller state encoding.
package cal_pkg;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_SELF_OFS  = 3'd1,
        CMD_SELF_GAIN = 3'd2,
        CMD_SELF_BOTH = 3'd3,
        CMD_SYS_OFS   = 3'd4,
        CMD_SYS_GAIN  = 3'd5
    } cal_cmd_e;

    typedef enum logic [1:0] {
        SEL_EXT  = 2'd0,
        SEL_ZERO = 2'd1,
        SEL_REF  = 2'd2
    } in_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DIV  = 2'd2
    } cal_state_e;

    // True for the five codes that start a calibration.
    function automatic logic cmd_known(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction

    // True when the command's first step measures gain.
    function automatic logic cmd_gain_first(input logic [2:0] code);
        return (code == CMD_SELF_GAIN) || (code == CMD_SYS_GAIN);
    endfunction

    // True when the command uses the internal zero/reference paths.
    function automatic logic cmd_is_self(input logic [2:0] code);
        return (code == CMD_SELF_OFS) || (code == CMD_SELF_GAIN) ||
               (code == CMD_SELF_BOTH);
    endfunction

endpackage

// File: rtl/cal_averager.sv
// Step averager. While enabled it counts conversions, skips the first
// SETTLE_N of each step and sums the next AVG_N. After the last one it
// pulses avg_valid with floor(sum / AVG_N) and rearms itself.
// Assumes AVG_N is a power of two. Clearing en drops a partial step.
module cal_averager #(
    parameter int DW       = 24,
    parameter int SETTLE_N = 3,
    parameter int AVG_N    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp,
    output logic          avg_valid,
    output logic [DW-1:0] avg
);
    localparam int STEP_N = SETTLE_N + AVG_N;
    localparam int CW     = $clog2(STEP_N + 1);
    localparam int LG     = $clog2(AVG_N);
    localparam int SW     = DW + LG;

    logic [CW-1:0]        idx;
    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] acc_nxt;
    logic signed [SW-1:0] smp_ext;

    generate
        if (LG > 0) begin : g_ext
            assign smp_ext = {{LG{smp[DW-1]}}, smp};
        end else begin : g_noext
            assign smp_ext = smp;
        end
    endgenerate

    // Running sum including the current sample once past the settle window.
    always_comb begin
        acc_nxt = acc;
        if (idx >= CW'(SETTLE_N)) begin
            acc_nxt = acc + smp_ext;
        end
    end

    // Step counter, accumulator and averaged result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            acc       <= '0;
            avg_valid <= 1'b0;
            avg       <= '0;
        end else begin
            avg_valid <= 1'b0;
            if (!en) begin
                idx <= '0;
                acc <= '0;
            end else if (smp_valid) begin
                if (idx == CW'(STEP_N - 1)) begin
                    idx       <= '0;
                    acc       <= '0;
                    avg_valid <= 1'b1;
                    avg       <= acc_nxt[SW-1 -: DW];
                end else begin
                    idx <= idx + 1'b1;
                    acc <= acc_nxt;
                end
            end
        end
    end
endmodule

// File: rtl/cal_divider.sv
// Restoring divider, one quotient bit per clock. start loads the
// dividend and divisor. done pulses NUM_W cycles later with the
// quotient. Assumes den is nonzero and start is not pulsed mid-run.
module cal_divider #(
    parameter int NUM_W = 46,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem;
    logic [DEN_W:0]   trial;
    logic [CW-1:0]    cnt;
    logic             run;

    // Partial remainder with the next dividend bit shifted in.
    assign trial = {rem, quo[NUM_W-1]};

    // Iteration: compare, subtract and shift one quotient bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_q <= '0;
            rem   <= '0;
            quo   <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                den_q <= den;
                rem   <= '0;
                quo   <= num;
                cnt   <= CW'(NUM_W);
                run   <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, den_q}) begin
                    rem <= DEN_W'(trial - {1'b0, den_q});
                    quo <= {quo[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= trial[DEN_W-1:0];
                    quo <= {quo[NUM_W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cal_corrector.sv
// Correction stage: out = clamp(floor((raw - ofs) * gain / 2^(DW-1))).
// The offset is two's complement and the gain is unsigned Q1.(DW-1).
// One register stage: out_valid follows en by one clock.
module cal_corrector #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] ofs,
    input  logic [DW-1:0] gain,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int PW = 2 * DW + 2;
    localparam logic signed [PW-1:0] HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW:0]   diff;
    logic signed [DW:0]   gain_s;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] res;
    logic [DW-1:0]        clamped;

    // Offset removal, gain multiply and scaling back to the output width.
    always_comb begin
        diff   = $signed({raw[DW-1], raw}) - $signed({ofs[DW-1], ofs});
        gain_s = $signed({1'b0, gain});
        prod   = diff * gain_s;
        res    = prod >>> (DW - 1);
    end

    // Saturation to the signed output range.
    always_comb begin
        if (res > HI) begin
            clamped = {1'b0, {(DW-1){1'b1}}};
        end else if (res < LO) begin
            clamped = {1'b1, {(DW-1){1'b0}}};
        end else begin
            clamped = res[DW-1:0];
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= en;
            if (en) begin
                out_data <= clamped;
            end
        end
    end
endmodule

// File: rtl/adc_cal_seq.sv
// Calibration sequencer top. Accepts a calibration command when idle
// and steers the converter input select. It runs one or two measuring
// steps through the averager and derives the offset word directly or
// the gain word through the serial divider. When idle it corrects the
// raw conversions. Assumes the upstream converter keeps producing
// conversions during calibration.
module adc_cal_seq #(
    parameter int DW       = 24,
    parameter int SETTLE_N = 3,
    parameter int AVG_N    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic          raw_valid,
    input  logic [DW-1:0] raw_data,
    input  logic          dec_change,
    input  logic          pga_change,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [DW-1:0] offset_reg,
    output logic [DW-1:0] gain_reg,
    output logic          busy,
    output logic          drdy_n,
    output logic          recal_req,
    output logic [1:0]    in_sel
);
    import cal_pkg::*;

    localparam int NUM_W = 2 * DW - 2;
    localparam logic [NUM_W-1:0] NUMER    = {{(DW-1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic [DW-1:0]    GAIN_ONE = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0]    GAIN_MAX = {DW{1'b1}};

    cal_state_e       state;
    logic             step_gain;
    logic             step_self;
    logic             chain_gain;
    logic             busy_q;
    logic             drdy_q;
    logic             recal_q;
    logic [DW-1:0]    ofs_q;
    logic [DW-1:0]    gain_q;

    logic             accept;
    logic             corr_en;
    logic             avg_valid;
    logic [DW-1:0]    avg;
    logic signed [DW:0] den;
    logic             den_pos;
    logic             div_start;
    logic             div_done;
    logic [NUM_W-1:0] quo;
    logic [DW-1:0]    quo_sat;
    logic             meas_done;
    logic             finish;
    in_sel_e          sel;

    // Command acceptance and correction enable for idle conversions.
    assign accept  = cmd_valid && !busy_q && cmd_known(cmd_code);
    assign corr_en = raw_valid && !busy_q && !accept;

    // Gain denominator: measured full-scale reading less stored offset.
    assign den     = $signed({avg[DW-1], avg}) - $signed({ofs_q[DW-1], ofs_q});
    assign den_pos = !den[DW] && (den != '0);

    // Step completion decode.
    assign meas_done = (state == ST_MEAS) && avg_valid;
    assign div_start = meas_done && step_gain && den_pos;
    assign finish    = (meas_done && !step_gain && !chain_gain) ||
                       (meas_done && step_gain && !den_pos) ||
                       ((state == ST_DIV) && div_done);

    // Clamp the wide quotient to the gain word.
    assign quo_sat = (|quo[NUM_W-1:DW]) ? GAIN_MAX : quo[DW-1:0];

    // Input select follows the step being measured.
    always_comb begin
        sel = SEL_EXT;
        if ((state != ST_IDLE) && step_self) begin
            sel = step_gain ? SEL_REF : SEL_ZERO;
        end
    end

    cal_averager #(
        .DW       (DW),
        .SETTLE_N (SETTLE_N),
        .AVG_N    (AVG_N)
    ) u_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state == ST_MEAS),
        .smp_valid (raw_valid),
        .smp       (raw_data),
        .avg_valid (avg_valid),
        .avg       (avg)
    );

    cal_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DW)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (NUMER),
        .den   (den[DW-1:0]),
        .done  (div_done),
        .quo   (quo)
    );

    cal_corrector #(
        .DW (DW)
    ) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (corr_en),
        .raw       (raw_data),
        .ofs       (ofs_q),
        .gain      (gain_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Controller state and step bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            step_gain  <= 1'b0;
            step_self  <= 1'b0;
            chain_gain <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state      <= ST_MEAS;
                        step_gain  <= cmd_gain_first(cmd_code);
                        step_self  <= cmd_is_self(cmd_code);
                        chain_gain <= (cmd_code == CMD_SELF_BOTH);
                    end
                end
                ST_MEAS: begin
                    if (meas_done) begin
                        if (!step_gain && chain_gain) begin
                            step_gain  <= 1'b1;
                            chain_gain <= 1'b0;
                        end else if (div_start) begin
                            state <= ST_DIV;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Calibration result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            gain_q <= GAIN_ONE;
        end else begin
            if (meas_done && !step_gain) begin
                ofs_q <= avg;
            end
            if (meas_done && step_gain && !den_pos) begin
                gain_q <= GAIN_MAX;
            end else if ((state == ST_DIV) && div_done) begin
                gain_q <= quo_sat;
            end
        end
    end

    // Busy, data-ready and recalibration flags; a change strobe beats completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            drdy_q  <= 1'b1;
            recal_q <= 1'b1;
        end else begin
            if (accept) begin
                busy_q <= 1'b1;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
            if (accept) begin
                drdy_q <= 1'b1;
            end else if (finish || corr_en) begin
                drdy_q <= 1'b0;
            end
            if (dec_change || pga_change) begin
                recal_q <= 1'b1;
            end else if (finish) begin
                recal_q <= 1'b0;
            end
        end
    end

    assign busy       = busy_q;
    assign drdy_n     = drdy_q;
    assign recal_req  = recal_q;
    assign offset_reg = ofs_q;
    assign gain_reg   = gain_q;
    assign in_sel     = sel;

endmodule

// File: rtl/adc_cal_seq_chk.sv
// Property checker for the calibration sequencer, bound to every
// instance of the top. Observes ports only.
module adc_cal_seq_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          dec_change,
    input logic          pga_change,
    input logic          out_valid,
    input logic [DW-1:0] offset_reg,
    input logic [DW-1:0] gain_reg,
    input logic          busy,
    input logic          drdy_n,
    input logic          recal_req,
    input logic [1:0]    in_sel
);
    // R7: data-ready held high for the whole calibration.
    p_drdy_high_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> drdy_n);

    // R7: data-ready low on the edge after completion.
    p_drdy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !drdy_n);

    // R2: a calibration only starts from a command strobe.
    p_busy_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R6: external input whenever idle.
    p_sel_ext_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (in_sel == 2'd0));

    // R6: only the three defined select codes appear.
    p_sel_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_sel != 2'd3);

    // R11: a change strobe leaves the recalibration flag set.
    p_recal_on_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_change || pga_change) |=> recal_req);

    // R9: no corrected output for a conversion taken while busy.
    p_no_out_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !out_valid);

    // R4: calibration words change only as a calibration ends.
    p_regs_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> ($stable(offset_reg) && $stable(gain_reg)));
endmodule

bind adc_cal_seq adc_cal_seq_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .dec_change (dec_change),
    .pga_change (pga_change),
    .out_valid  (out_valid),
    .offset_reg (offset_reg),
    .gain_reg   (gain_reg),
    .busy       (busy),
    .drdy_n     (drdy_n),
    .recal_req  (recal_req),
    .in_sel     (in_sel)
);

// File: tb/tb_adc_cal_seq.sv
`timescale 1ns/1ps
module tb_adc_cal_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic        raw_valid = 1'b0;
    logic [23:0] raw_data = 24'd0;
    logic        dec_change = 1'b0;
    logic        pga_change = 1'b0;
    logic        out_valid;
    logic [23:0] out_data;
    logic [23:0] offset_reg;
    logic [23:0] gain_reg;
    logic        busy;
    logic        drdy_n;
    logic        recal_req;
    logic [1:0]  in_sel;

    always #2 clk = ~clk;

    adc_cal_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .raw_valid(raw_valid), .raw_data(raw_data), .dec_change(dec_change),
        .pga_change(pga_change), .out_valid(out_valid), .out_data(out_data),
        .offset_reg(offset_reg), .gain_reg(gain_reg), .busy(busy),
        .drdy_n(drdy_n), .recal_req(recal_req), .in_sel(in_sel)
    );

    int     n_chk = 0;
    int     n_err = 0;
    longint exp_q[$];
    longint m_ofs  = 0;
    longint m_gain = 64'd8388608;

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    // R9 model: offset removal, Q1.23 gain, floor, clamp.
    function automatic longint corr(input longint raw);
        longint r;
        r = ((raw - m_ofs) * m_gain) >>> 23;
        if (r > 64'sd8388607) r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return r;
    endfunction

    // R5 model.
    function automatic longint calc_gain(input longint meas);
        longint d;
        longint q;
        d = meas - m_ofs;
        if (d <= 0) return 64'd16777215;
        q = ((64'sd1 <<< 46) - (64'sd1 <<< 23)) / d;
        if (q > 64'd16777215) q = 64'd16777215;
        return q;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic raw_idle(input longint v);
        @(negedge clk);
        raw_valid = 1'b1;
        raw_data  = v[23:0];
        exp_q.push_back(corr(v));
        @(negedge clk);
        raw_valid = 1'b0;
    endtask

    task automatic raw_cal(input longint v);
        @(negedge clk);
        raw_valid = 1'b1;
        raw_data  = v[23:0];
        @(negedge clk);
        raw_valid = 1'b0;
    endtask

    task automatic send_cmd(input int c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = 3'(c);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    // Scoreboard monitor: every corrected output must match the next prediction.
    always @(negedge clk) begin : mon
        longint e;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL R9 unexpected output: actual %0d expected none", sx(out_data));
            end else begin
                e = exp_q.pop_front();
                chk("R9", sx(out_data), e, "corrected output");
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R7 watchdog: actual busy=%0d expected run to end", busy);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        longint g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", busy, 0, "busy");
        chk("R1", drdy_n, 1, "drdy_n");
        chk("R1", recal_req, 1, "recal_req");
        chk("R1", out_valid, 0, "out_valid");
        chk("R1", in_sel, 0, "in_sel");
        chk("R1", offset_reg, 0, "offset_reg");
        chk("R1", gain_reg, 24'h800000, "gain_reg");

        // R2 unknown codes ignored
        send_cmd(0); chk("R2", busy, 0, "code 0");
        send_cmd(6); chk("R2", busy, 0, "code 6");
        send_cmd(7); chk("R2", busy, 0, "code 7");

        // R9/R10 identity correction, data-ready drops on output
        raw_idle(1000);
        chk("R10", drdy_n, 0, "drdy_n after output");
        raw_idle(-777);

        // System offset with a change strobe on the completion edge
        send_cmd(4);
        chk("R7", busy, 1, "busy after sys offset");
        chk("R7", drdy_n, 1, "drdy_n during cal");
        chk("R6", in_sel, 0, "sys offset select");
        raw_cal(9999); raw_cal(9999); raw_cal(9999);
        raw_cal(100);
        send_cmd(5);                      // R8 ignored while busy
        raw_cal(101); raw_cal(102);
        idle_cycles(3);
        chk("R3", busy, 1, "busy after six conversions");
        raw_cal(104);
        dec_change = 1'b1;
        @(negedge clk);
        dec_change = 1'b0;
        chk("R7", busy, 0, "busy at completion");
        chk("R7", drdy_n, 0, "drdy_n at completion");
        chk("R11", recal_req, 1, "recal kept by same-cycle change");
        chk("R4", sx(offset_reg), 101, "sys offset average");
        m_ofs = 101;
        idle_cycles(4);
        chk("R8", busy, 0, "ignored command did not start");
        chk("R8", gain_reg, 24'h800000, "gain untouched by ignored command");

        // System gain
        send_cmd(5);
        chk("R6", in_sel, 0, "sys gain select");
        raw_cal(0); raw_cal(0); raw_cal(0);
        for (int i = 0; i < 4; i++) raw_cal(8000101);
        wait_idle();
        m_gain = calc_gain(8000101);
        chk("R5", gain_reg, m_gain, "sys gain word");
        chk("R11", recal_req, 0, "recal cleared");
        chk("R7", drdy_n, 0, "drdy_n after gain cal");

        // R9 corrections including both clamps
        raw_idle(101);
        raw_idle(5000101);
        raw_idle(8388607);
        raw_idle(-8388608);
        raw_idle(-3000000);

        // Combined self calibration
        send_cmd(3);
        chk("R6", in_sel, 1, "self offset select");
        raw_cal(77); raw_cal(77); raw_cal(77);
        raw_cal(-50); raw_cal(-50); raw_cal(-50); raw_cal(-51);
        idle_cycles(2);
        chk("R3", busy, 1, "busy between combined steps");
        chk("R6", in_sel, 2, "self gain select");
        chk("R4", sx(offset_reg), -51, "self offset floor average");
        m_ofs = -51;
        raw_cal(5); raw_cal(5); raw_cal(5);
        raw_cal(7000000); raw_cal(7000000); raw_cal(7000000);
        idle_cycles(3);
        chk("R3", busy, 1, "busy after thirteen conversions");
        raw_cal(7000000);
        wait_idle();
        chk("R3", busy, 0, "done after fourteen conversions");
        m_gain = calc_gain(7000000);
        chk("R5", gain_reg, m_gain, "self gain word");
        raw_idle(4000000);

        // Self gain with a non-positive difference
        send_cmd(2);
        chk("R6", in_sel, 2, "self gain only select");
        raw_cal(0); raw_cal(0); raw_cal(0);
        for (int i = 0; i < 4; i++) raw_cal(-100);
        wait_idle();
        g = 64'd16777215;
        m_gain = g;
        chk("R5", gain_reg, g, "gain clamp on negative difference");

        // Change strobe while idle, then self offset clears it
        @(negedge clk); pga_change = 1'b1;
        @(negedge clk); pga_change = 1'b0;
        chk("R11", recal_req, 1, "pga change sets flag");
        send_cmd(1);
        chk("R6", in_sel, 1, "self offset only select");
        raw_cal(0); raw_cal(0); raw_cal(0);
        for (int i = 0; i < 4; i++) raw_cal(3);
        wait_idle();
        chk("R4", sx(offset_reg), 3, "self offset word");
        chk("R11", recal_req, 0, "flag cleared by self offset");
        m_ofs = 3;
        raw_idle(1000);
        raw_idle(-1000);
        idle_cycles(3);
        chk("R9", exp_q.size(), 0, "scoreboard drained");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule